// File: doc/BRIEF.md
# Shared Cache-Maintenance Command Queue Frontend

This block is the register-side frontend of an outer cache controller that several CPUs share. A CPU books a maintenance request (invalidate, clean or flush, over an address range or over the whole cache) by writing a mode word, a start address and a size into a set of shared command registers. Exclusive use of those registers is arbitrated in hardware: the first CPU to write the mode word owns them until it reads back its own registration status. That read commits the request into a small in-order queue, or reports why the request was refused.

Accepted requests leave the queue one at a time towards a maintenance engine over a simple request/done handshake. Each CPU sees its own status through the same register addresses, selected by the CPU number that travels with every bus access. A CPU can see whether its requests are queued or executing, and can see a completion flag when it asked for one. A sync primitive lets software wait until the queue and the engine are both empty: after a sync request, a read of the primitive register is held off until the drain is finished.

Registers are addressed by a 3-bit index: 0 mode, 1 address, 2 size, 3 registration status, 4 queue status, 5 primitive.

Top module: `cmq_frontend`

## Requirements
- R1: After reset no request is presented to the engine, the bus is ready, and the registration-status and queue-status registers of every CPU read as zero.
- R2: A mode write (index 0) by a CPU while another CPU owns the command registers is refused. So is an address (index 1) or size (index 2) write by any non-owner. A refused write sets bit 0 of that CPU's registration status (index 3), and reading index 3 clears that bit.
- R3: Reading index 3 by the owning CPU releases ownership. If the queue has room and the owner has no failure flag, the read returns 0 and the request is appended to the queue.
- R4: If the queue already holds DEPTH entries when the owner reads index 3, the read returns bit 1 set and nothing is queued. Ownership is still released.
- R5: Queued requests reach the engine strictly in acceptance order, one at a time. `eng_req` and its fields hold steady until `eng_done`, and `eng_req` is low in the cycle after a completion.
- R6: The scope field is mode bits 18:17. Value 0 is a range operation, which presents the written address and size. Any other value is a whole-cache operation, which presents address and size as zero.
- R7: Mode bits 1:0 carry the operation code (0 invalidate, 1 clean, 2 flush) and appear unchanged on `eng_op`.
- R8: When a request with mode bit 15 set completes, bit 2 of the requesting CPU's queue status (index 4) is set. No other CPU's flag is set. A request without bit 15 sets no flag. Writing 1 to bit 2 of index 4 clears the writer's flag.
- R9: In a CPU's queue status, bit 1 reads 1 while the engine is executing that CPU's request. Bit 0 reads 1 while at least one of its requests waits in the queue.
- R10: Writing 0x8 to index 5 requests a sync. A later read of index 5 is stalled (`bus_ready` low) until the queue is empty and the engine idle, then returns 0. Any other value written to index 5 has no effect.
- R11: `bus_ready` is low only during a read of index 5; every other access completes in its first cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Register access present |
| bus_write | input | 1 | 1 write, 0 read |
| bus_reg | input | 3 | Register index |
| bus_cpu | input | $clog2(NCPU) | Number of the accessing CPU |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while bus_ready is high |
| bus_ready | output | 1 | Access completes at this clock edge |
| eng_req | output | 1 | Request presented to the engine |
| eng_op | output | 2 | Operation code |
| eng_all | output | 1 | Whole-cache operation |
| eng_addr | output | AW | Range start (zero for whole-cache) |
| eng_size | output | AW | Range size (zero for whole-cache) |
| eng_cpu | output | $clog2(NCPU) | Requesting CPU |
| eng_done | input | 1 | Engine finished the presented request |

## Verification
Contention is tried by letting two CPUs race for the mode register. This separates a refused write from a silently overwritten one, and shows that ownership moves only on the owner's status read. A queue filled against a stalled engine separates the full report from the ordinary failure bit, and the per-CPU queued and executing bits from each other. Mixed range and whole-cache requests with different operation codes and notify settings tell apart field routing, address masking and which CPU gets the completion flag. Sync is tried with a busy engine and with an idle one, and the stall is compared against a write of a non-sync value.

// File: rtl/cmq_pkg.sv
package cmq_pkg;
    localparam int DW    = 32;
    localparam int REG_W = 3;

    localparam logic [REG_W-1:0] REG_MODE  = 3'd0;
    localparam logic [REG_W-1:0] REG_ADDR  = 3'd1;
    localparam logic [REG_W-1:0] REG_SIZE  = 3'd2;
    localparam logic [REG_W-1:0] REG_RSTAT = 3'd3;
    localparam logic [REG_W-1:0] REG_QSTAT = 3'd4;
    localparam logic [REG_W-1:0] REG_PRIM  = 3'd5;

    localparam int SCOPE_LO   = 17;
    localparam int NOTIFY_BIT = 15;
    localparam int RS_FULL    = 1;
    localparam int RS_FAIL    = 0;
    localparam int QS_DONE    = 2;
    localparam int QS_EXEC    = 1;
    localparam int QS_QUEUED  = 0;
    localparam logic [DW-1:0] SYNC_CODE = 32'h8;
endpackage

// File: rtl/cmq_fifo.sv
module cmq_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push,
    input  logic                       pop,
    input  logic [W-1:0]               wdata,
    output logic [W-1:0]               rdata,
    output logic [$clog2(DEPTH+1)-1:0] count
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [PW-1:0] wp;
        logic [PW-1:0] rp;
        logic [CW-1:0] cnt;
    } fifo_st_t;

    fifo_st_t q, d;
    logic [W-1:0] mem [DEPTH];

    function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    always_comb begin
        d = q;
        if (push) d.wp = nxt(q.wp);
        if (pop)  d.rp = nxt(q.rp);
        case ({push, pop})
            2'b10:   d.cnt = q.cnt + CW'(1);
            2'b01:   d.cnt = q.cnt - CW'(1);
            default: d.cnt = q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_ff @(posedge clk) begin
        if (push) mem[q.wp] <= wdata;
    end

    assign rdata = mem[q.rp];
    assign count = q.cnt;
endmodule

// File: rtl/cmq_lock.sv
module cmq_lock #(
    parameter int NCPU = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    take,
    input  logic                    rel,
    input  logic [$clog2(NCPU)-1:0] cpu,
    output logic                    held,
    output logic [$clog2(NCPU)-1:0] owner
);
    localparam int CW = $clog2(NCPU);

    typedef struct packed {
        logic          held;
        logic [CW-1:0] owner;
    } lock_st_t;

    lock_st_t q, d;

    always_comb begin
        d = q;
        if (rel) begin
            d.held = 1'b0;
        end else if (take) begin
            d.held  = 1'b1;
            d.owner = cpu;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign held  = q.held;
    assign owner = q.owner;
endmodule

// File: rtl/cmq_frontend.sv
module cmq_frontend
    import cmq_pkg::*;
#(
    parameter int NCPU  = 4,
    parameter int DEPTH = 4,
    parameter int AW    = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    bus_valid,
    input  logic                    bus_write,
    input  logic [2:0]              bus_reg,
    input  logic [$clog2(NCPU)-1:0] bus_cpu,
    input  logic [31:0]             bus_wdata,
    output logic [31:0]             bus_rdata,
    output logic                    bus_ready,
    output logic                    eng_req,
    output logic [1:0]              eng_op,
    output logic                    eng_all,
    output logic [AW-1:0]           eng_addr,
    output logic [AW-1:0]           eng_size,
    output logic [$clog2(NCPU)-1:0] eng_cpu,
    input  logic                    eng_done
);
    localparam int CW = $clog2(NCPU);
    localparam int QW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [1:0]    op;
        logic          all;
        logic          notify;
        logic [AW-1:0] addr;
        logic [AW-1:0] size;
        logic [CW-1:0] cpu;
    } entry_t;

    localparam int EW = $bits(entry_t);

    typedef struct packed {
        logic [1:0]                m_op;
        logic                      m_all;
        logic                      m_nt;
        logic [AW-1:0]             addr;
        logic [AW-1:0]             size;
        logic [NCPU-1:0]           fail;
        logic [NCPU-1:0]           done;
        logic [NCPU-1:0][QW-1:0]   qcnt;
        logic                      act_vld;
        entry_t                    act;
        logic                      sync;
    } state_t;

    state_t q, d;

    logic          push, pop;
    entry_t        new_e, head_e;
    logic [EW-1:0] head_raw;
    logic [QW-1:0] fifo_cnt;
    logic          lk_take, lk_rel, lk_held;
    logic [CW-1:0] lk_owner;
    logic          rd, wr, own, full, busy;

    cmq_fifo #(.W(EW), .DEPTH(DEPTH)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push),
        .pop   (pop),
        .wdata (new_e),
        .rdata (head_raw),
        .count (fifo_cnt)
    );

    cmq_lock #(.NCPU(NCPU)) u_lock (
        .clk   (clk),
        .rst_n (rst_n),
        .take  (lk_take),
        .rel   (lk_rel),
        .cpu   (bus_cpu),
        .held  (lk_held),
        .owner (lk_owner)
    );

    assign head_e = entry_t'(head_raw);

    always_comb begin
        d         = q;
        push      = 1'b0;
        pop       = 1'b0;
        lk_take   = 1'b0;
        lk_rel    = 1'b0;
        bus_ready = 1'b1;
        bus_rdata = '0;

        rd   = bus_valid && !bus_write;
        wr   = bus_valid && bus_write;
        own  = lk_held && (lk_owner == bus_cpu);
        full = (fifo_cnt == QW'(DEPTH));
        busy = (fifo_cnt != '0) || q.act_vld;

        new_e.op     = q.m_op;
        new_e.all    = q.m_all;
        new_e.notify = q.m_nt;
        new_e.addr   = q.m_all ? '0 : q.addr;
        new_e.size   = q.m_all ? '0 : q.size;
        new_e.cpu    = bus_cpu;

        // read data and the sync stall
        if (rd) begin
            case (bus_reg)
                REG_RSTAT: begin
                    bus_rdata[RS_FULL] = own && full;
                    bus_rdata[RS_FAIL] = q.fail[bus_cpu];
                end
                REG_QSTAT: begin
                    bus_rdata[QS_DONE]   = q.done[bus_cpu];
                    bus_rdata[QS_EXEC]   = q.act_vld && (q.act.cpu == bus_cpu);
                    bus_rdata[QS_QUEUED] = (q.qcnt[bus_cpu] != '0);
                end
                REG_PRIM: bus_ready = !(q.sync && busy);
                default: ;
            endcase
        end

        // engine slot: retire, then refill from the queue head
        if (q.act_vld && eng_done) d.act_vld = 1'b0;
        if (!q.act_vld && (fifo_cnt != '0)) begin
            pop                  = 1'b1;
            d.act_vld            = 1'b1;
            d.act                = head_e;
            d.qcnt[head_e.cpu]   = d.qcnt[head_e.cpu] - QW'(1);
        end

        if (q.sync && !busy) d.sync = 1'b0;

        if (wr) begin
            case (bus_reg)
                REG_MODE: begin
                    if (!lk_held || own) begin
                        lk_take = 1'b1;
                        d.m_op  = bus_wdata[1:0];
                        d.m_all = |bus_wdata[SCOPE_LO+1:SCOPE_LO];
                        d.m_nt  = bus_wdata[NOTIFY_BIT];
                    end else begin
                        d.fail[bus_cpu] = 1'b1;
                    end
                end
                REG_ADDR: begin
                    if (own) d.addr = bus_wdata[AW-1:0];
                    else     d.fail[bus_cpu] = 1'b1;
                end
                REG_SIZE: begin
                    if (own) d.size = bus_wdata[AW-1:0];
                    else     d.fail[bus_cpu] = 1'b1;
                end
                REG_QSTAT: if (bus_wdata[QS_DONE]) d.done[bus_cpu] = 1'b0;
                REG_PRIM:  if (bus_wdata == SYNC_CODE) d.sync = 1'b1;
                default: ;
            endcase
        end

        // registration commit on the status read
        if (rd && (bus_reg == REG_RSTAT)) begin
            d.fail[bus_cpu] = 1'b0;
            if (own) begin
                lk_rel = 1'b1;
                if (!full && !q.fail[bus_cpu]) begin
                    push               = 1'b1;
                    d.qcnt[bus_cpu]    = d.qcnt[bus_cpu] + QW'(1);
                end
            end
        end

        if (q.act_vld && eng_done && q.act.notify) d.done[q.act.cpu] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign eng_req  = q.act_vld;
    assign eng_op   = q.act.op;
    assign eng_all  = q.act.all;
    assign eng_addr = q.act.addr;
    assign eng_size = q.act.size;
    assign eng_cpu  = q.act.cpu;
endmodule

// File: rtl/cmq_frontend_chk.sv
module cmq_frontend_chk #(
    parameter int CW = 2,
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bus_valid,
    input logic          bus_write,
    input logic [2:0]    bus_reg,
    input logic          bus_ready,
    input logic          eng_req,
    input logic          eng_done,
    input logic [1:0]    eng_op,
    input logic          eng_all,
    input logic [AW-1:0] eng_addr,
    input logic [AW-1:0] eng_size,
    input logic [CW-1:0] eng_cpu,
    input logic          lk_held,
    input logic          lk_rel,
    input logic [CW-1:0] lk_owner
);
    p_stall_only_prim_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_ready |-> (bus_valid && !bus_write && bus_reg == 3'd5));

    p_req_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_req && !eng_done) |=> (eng_req && $stable(eng_addr) && $stable(eng_size)
                                    && $stable(eng_cpu) && $stable(eng_op) && $stable(eng_all)));

    p_gap_after_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_req && eng_done) |=> !eng_req);

    p_all_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_req && eng_all) |-> (eng_addr == '0 && eng_size == '0));

    p_owner_kept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_held && !lk_rel) |=> (lk_held && $stable(lk_owner)));

    p_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
        lk_rel |=> !lk_held);
endmodule

bind cmq_frontend cmq_frontend_chk #(.CW(CW), .AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_reg   (bus_reg),
    .bus_ready (bus_ready),
    .eng_req   (eng_req),
    .eng_done  (eng_done),
    .eng_op    (eng_op),
    .eng_all   (eng_all),
    .eng_addr  (eng_addr),
    .eng_size  (eng_size),
    .eng_cpu   (eng_cpu),
    .lk_held   (lk_held),
    .lk_rel    (lk_rel),
    .lk_owner  (lk_owner)
);

// File: tb/sim_cmq_frontend.sv
`timescale 1ns/1ps
module sim_cmq_frontend;
    localparam int NCPU  = 4;
    localparam int DEPTH = 4;
    localparam int AW    = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0, bus_write = 1'b0;
    logic [2:0]  bus_reg = '0;
    logic [1:0]  bus_cpu = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_ready;
    logic        eng_req, eng_all;
    logic [1:0]  eng_op, eng_cpu;
    logic [31:0] eng_addr, eng_size;
    logic        eng_done = 1'b0;

    int checks = 0, errors = 0;
    int elat = 3, ecnt = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    cmq_frontend #(.NCPU(NCPU), .DEPTH(DEPTH), .AW(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_reg(bus_reg), .bus_cpu(bus_cpu), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_ready(bus_ready), .eng_req(eng_req),
        .eng_op(eng_op), .eng_all(eng_all), .eng_addr(eng_addr),
        .eng_size(eng_size), .eng_cpu(eng_cpu), .eng_done(eng_done)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h exp %h", tag, got, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    typedef struct {
        logic [1:0]  op;
        bit          all;
        bit          nt;
        logic [31:0] a;
        logic [31:0] s;
        int          cpu;
    } ment_t;

    ment_t       mq[$];
    ment_t       mact;
    bit          mact_v, m_held, m_sync, m_all, m_nt;
    int          m_own;
    logic [1:0]  m_op;
    logic [31:0] m_addr, m_size;
    bit          m_fail[NCPU];
    bit          m_done[NCPU];

    function automatic bit m_busy();
        return (mq.size() != 0) || mact_v;
    endfunction

    function automatic logic [31:0] m_read(input int r, input int c);
        logic [31:0] v;
        v = '0;
        if (r == 3) begin
            v[1] = m_held && (m_own == c) && (mq.size() == DEPTH);
            v[0] = m_fail[c];
        end else if (r == 4) begin
            v[2] = m_done[c];
            v[1] = mact_v && (mact.cpu == c);
            foreach (mq[i]) if (mq[i].cpu == c) v[0] = 1'b1;
        end
        return v;
    endfunction

    always @(posedge clk) begin : model
        bit    busy, own, full, rdv, wrv, pre_v, pre_fail;
        ment_t pre_a, ne;
        int    c;
        if (!rst_n) begin
            mq.delete();
            mact_v = 0; m_held = 0; m_sync = 0; m_own = 0;
            m_op = 0; m_all = 0; m_nt = 0; m_addr = 0; m_size = 0;
            foreach (m_fail[i]) begin m_fail[i] = 0; m_done[i] = 0; end
        end else begin
            c        = int'(bus_cpu);
            busy     = m_busy();
            own      = m_held && (m_own == c);
            full     = (mq.size() == DEPTH);
            pre_fail = m_fail[c];
            rdv      = bus_valid && !bus_write && !(bus_reg == 3'd5 && m_sync && busy);
            wrv      = bus_valid && bus_write;
            pre_v    = mact_v;
            pre_a    = mact;
            if (pre_v && eng_done) mact_v = 0;
            if (!pre_v && mq.size() > 0) begin
                mact   = mq.pop_front();
                mact_v = 1;
            end
            if (m_sync && !busy) m_sync = 0;
            if (wrv) begin
                case (bus_reg)
                    3'd0: if (!m_held || own) begin
                        m_held = 1; m_own = c; m_op = bus_wdata[1:0];
                        m_all = (bus_wdata[18:17] != 2'b00); m_nt = bus_wdata[15];
                    end else m_fail[c] = 1;
                    3'd1: if (own) m_addr = bus_wdata; else m_fail[c] = 1;
                    3'd2: if (own) m_size = bus_wdata; else m_fail[c] = 1;
                    3'd4: if (bus_wdata[2]) m_done[c] = 0;
                    3'd5: if (bus_wdata == 32'h8) m_sync = 1;
                    default: ;
                endcase
            end
            if (rdv && bus_reg == 3'd3) begin
                m_fail[c] = 0;
                if (own) begin
                    m_held = 0;
                    if (!full && !pre_fail) begin
                        ne.op = m_op; ne.all = m_all; ne.nt = m_nt;
                        ne.a = m_all ? 32'h0 : m_addr;
                        ne.s = m_all ? 32'h0 : m_size;
                        ne.cpu = c;
                        mq.push_back(ne);
                    end
                end
            end
            if (pre_v && eng_done && pre_a.nt) m_done[pre_a.cpu] = 1;
        end
    end

    // engine stub
    always @(negedge clk) begin
        if (eng_req && ecnt >= elat) begin
            eng_done = 1'b1; ecnt = 0;
        end else if (eng_req) begin
            eng_done = 1'b0; ecnt++;
        end else begin
            eng_done = 1'b0; ecnt = 0;
        end
    end

    // per-clock comparison of the engine side
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            #2;
            chk("R5 eng_req", {31'b0, eng_req}, {31'b0, mact_v});
            if (mact_v && eng_req) begin
                chk("R7 eng_op", {30'b0, eng_op}, {30'b0, mact.op});
                chk("R6 eng_all", {31'b0, eng_all}, {31'b0, mact.all});
                chk("R6 eng_addr", eng_addr, mact.a);
                chk("R6 eng_size", eng_size, mact.s);
                chk("R5 eng_cpu order", {30'b0, eng_cpu}, mact.cpu);
            end
        end
    end

    // ---------------- bus tasks ----------------
    task automatic wr(input logic [2:0] r, input logic [1:0] c, input logic [31:0] v);
        @(negedge clk);
        bus_valid = 1; bus_write = 1; bus_reg = r; bus_cpu = c; bus_wdata = v;
        #1;
        chk("R11 write ready", {31'b0, bus_ready}, 32'd1);
        @(posedge clk);
        #1 bus_valid = 0;
    endtask

    task automatic rd(input logic [2:0] r, input logic [1:0] c, input string tag,
                      output logic [31:0] got, output int stalls);
        bit er;
        stalls = 0;
        @(negedge clk);
        bus_valid = 1; bus_write = 0; bus_reg = r; bus_cpu = c;
        #1;
        forever begin
            er = !(r == 3'd5 && m_sync && m_busy());
            chk({tag, " R11 ready"}, {31'b0, bus_ready}, {31'b0, er});
            if (bus_ready) break;
            stalls++;
            if (stalls > 5000) break;
            @(negedge clk);
            #1;
        end
        got = bus_rdata;
        chk({tag, " model"}, got, m_read(int'(r), int'(c)));
        @(posedge clk);
        #1 bus_valid = 0;
    endtask

    task automatic rdx(input logic [2:0] r, input logic [1:0] c, input string tag,
                       input logic [31:0] exp);
        logic [31:0] g;
        int s;
        rd(r, c, tag, g, s);
        chk(tag, g, exp);
    endtask

    task automatic wait_drain();
        int n;
        n = 0;
        while ((eng_req || m_busy()) && n < 20000) begin
            @(negedge clk);
            n++;
        end
        repeat (2) @(negedge clk);
    endtask

    initial begin
        #(150000 * 5);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog R5 got timeout exp completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] g;
        int st;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        // R1 reset state
        chk("R1 eng_req idle", {31'b0, eng_req}, 32'd0);
        chk("R1 bus ready", {31'b0, bus_ready}, 32'd1);
        for (int c = 0; c < NCPU; c++) begin
            rdx(3'd3, 2'(c), "R1 rstat", 32'd0);
            rdx(3'd4, 2'(c), "R1 qstat", 32'd0);
        end

        // R3 R7 R8: range flush with notify from cpu0
        wr(3'd0, 2'd0, 32'h0000_8002);
        wr(3'd1, 2'd0, 32'h0000_1000);
        wr(3'd2, 2'd0, 32'h0000_0040);
        rdx(3'd3, 2'd0, "R3 commit accepted", 32'd0);
        wait_drain();
        rdx(3'd4, 2'd0, "R8 done flag set", 32'd4);
        rdx(3'd4, 2'd1, "R8 other cpu untouched", 32'd0);
        wr(3'd4, 2'd0, 32'd4);
        rdx(3'd4, 2'd0, "R8 flag cleared", 32'd0);

        // R2 contention
        wr(3'd0, 2'd1, 32'h0000_0000);
        wr(3'd0, 2'd2, 32'h0000_0002);
        wr(3'd1, 2'd2, 32'h0000_0055);
        rdx(3'd3, 2'd2, "R2 refused write flagged", 32'd1);
        rdx(3'd3, 2'd2, "R2 flag cleared by read", 32'd0);
        wr(3'd1, 2'd1, 32'h0000_2000);
        wr(3'd2, 2'd1, 32'h0000_0080);
        rdx(3'd3, 2'd1, "R3 owner commit", 32'd0);
        wr(3'd0, 2'd2, 32'h0000_8001);
        wr(3'd1, 2'd2, 32'h0000_3000);
        wr(3'd2, 2'd2, 32'h0000_0100);
        rdx(3'd3, 2'd2, "R3 retry after release", 32'd0);
        wait_drain();
        rdx(3'd4, 2'd1, "R8 no notify no flag", 32'd0);
        rdx(3'd4, 2'd2, "R8 notify flag", 32'd4);
        wr(3'd4, 2'd2, 32'd4);

        // R6 whole-cache clean ignores address and size
        wr(3'd0, 2'd3, 32'h0002_0001);
        wr(3'd1, 2'd3, 32'h000d_ead0);
        wr(3'd2, 2'd3, 32'h0000_0123);
        rdx(3'd3, 2'd3, "R6 whole commit", 32'd0);
        repeat (3) @(negedge clk);
        #3;
        chk("R6 whole req", {31'b0, eng_req}, 32'd1);
        chk("R6 whole addr zero", eng_addr, 32'd0);
        chk("R6 whole size zero", eng_size, 32'd0);
        chk("R7 clean code", {30'b0, eng_op}, 32'd1);
        wait_drain();

        // R4 R9 queue full against a stalled engine
        elat = 100000;
        for (int i = 0; i < 5; i++) begin
            wr(3'd0, 2'(i % 4), 32'h0000_8000 | 32'(i % 3));
            wr(3'd1, 2'(i % 4), 32'h0001_0000 + 32'(i * 256));
            wr(3'd2, 2'(i % 4), 32'h0000_0040);
            rdx(3'd3, 2'(i % 4), "R5 fill accepted", 32'd0);
        end
        wr(3'd0, 2'd1, 32'h0000_0002);
        rdx(3'd3, 2'd1, "R4 full reported", 32'd2);
        rdx(3'd4, 2'd0, "R9 exec and queued", 32'd3);
        rdx(3'd4, 2'd1, "R9 queued only", 32'd1);
        rdx(3'd4, 2'd3, "R9 queued cpu3", 32'd1);
        wr(3'd0, 2'd2, 32'h0000_0001);
        rdx(3'd3, 2'd2, "R4 lock released after full", 32'd2);
        elat = 2;
        wait_drain();
        rdx(3'd4, 2'd0, "R8 done after drain", 32'd4);
        rdx(3'd4, 2'd3, "R9 drained cpu3", 32'd4);
        for (int c = 0; c < NCPU; c++) wr(3'd4, 2'(c), 32'd4);

        // R10 sync with a busy engine
        elat = 20;
        for (int i = 0; i < 2; i++) begin
            wr(3'd0, 2'd0, 32'h0000_0000);
            wr(3'd1, 2'd0, 32'h0000_4000);
            wr(3'd2, 2'd0, 32'h0000_0020);
            rdx(3'd3, 2'd0, "R10 setup commit", 32'd0);
        end
        wr(3'd5, 2'd0, 32'h0000_0008);
        rd(3'd5, 2'd0, "R10 sync read", g, st);
        chk("R10 sync stalled", {31'b0, (st > 0)}, 32'd1);
        chk("R10 sync data", g, 32'd0);
        #2;
        chk("R10 drained at release", {31'b0, eng_req}, 32'd0);

        // R10 non-sync value has no effect
        wr(3'd0, 2'd1, 32'h0000_0001);
        rdx(3'd3, 2'd1, "R10 setup2", 32'd0);
        wr(3'd5, 2'd1, 32'h0000_0005);
        rd(3'd5, 2'd1, "R10 other value", g, st);
        chk("R10 no stall on other value", st, 32'd0);
        wait_drain();
        wr(3'd5, 2'd0, 32'h0000_0008);
        rd(3'd5, 2'd0, "R10 idle sync", g, st);
        chk("R10 idle sync no stall", st, 32'd0);

        repeat (4) @(negedge clk);
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule